// File: doc/BRIEF.md
# Dual-Edge 12-Bit Word Deserializer

This block turns two retimed serial bit lanes into parallel 12-bit sample words. The upstream alignment stage delivers one bit pair on every cycle of the fast bit clock. One lane carries the bit that was sampled on the rising edge, and the other lane carries the bit sampled on the falling edge. The even and odd bits each run through their own 6-stage shift chain. Once every six clocks a capture strobe copies both chains into holding registers. On the next clock an interleaving multiplexer merges the two halves into the output word and raises a one-cycle valid.

Framing is set by two controls. Each cycle with `slip_req` high holds back the word-phase counter by one cycle. This moves the word boundary later by one bit pair. The `lane_swap` input chooses which lane holds the earlier bit of each pair. Six pair phases combined with the two lane orders give all twelve bit offsets. A word therefore spans six consecutive bit-clock cycles, which is one word period at a six-to-one clock ratio.

Top module: `dsr_deser12`

## Requirements
- R1: While `rst_n` is low, `word_valid` is 0 and `word_out` is all zeros, whatever the lanes carry; after `rst_n` goes high they stay so until the first word.
- R2: With no slip request, count clock edges from the first edge after reset release as edge 1. The pairs presented before edges 1 to 6 form the first word. That word appears with `word_valid` high after edge 7. A new word then follows every 6 edges, and `word_valid` is high for exactly one cycle in each group of six.
- R3: With `lane_swap` = 0, the word is most significant bit first and the rise lane holds the earlier bit of each pair. Pair j of the word, with j = 0 the oldest, drives `word_out[11-2j]` from `bit_rise` and `word_out[10-2j]` from `bit_fall`.
- R4: With `lane_swap` = 1, the lanes trade places. Pair j drives `word_out[11-2j]` from `bit_fall` and `word_out[10-2j]` from `bit_rise`.
- R5: Each clock edge at which `slip_req` is high delays that word boundary and every later one by one cycle. After d slip edges at edges 1 to d, the first word holds pairs d+1 to d+6 and appears after edge d+7.
- R6: Between valid pulses, `word_out` holds its last value.
- R7: Two valid pulses are never closer than 6 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one bit pair per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_rise | input | 1 | Lane holding the bit captured on the rising edge |
| bit_fall | input | 1 | Lane holding the bit captured on the falling edge |
| slip_req | input | 1 | Per-cycle request to delay the word boundary by one pair |
| lane_swap | input | 1 | Selects which lane carries the earlier bit of a pair |
| word_out | output | 12 | Assembled parallel word, MSB first |
| word_valid | output | 1 | One-cycle strobe when a new word is presented |

## Verification
The assertions assume that `lane_swap` is stable across each capture edge. They also assume that slip requests come only as deliberate alignment steps, so the valid spacing can only grow and never shrink. The stimulus keeps within these assumptions. It fixes `lane_swap` for each full run and raises `slip_req` only on the first d edges after reset, for d from 0 to 5. The bench sweeps all twelve pair-phase and lane-order combinations with fresh pseudo-random lane data. It checks every cycle's valid and word against words built arithmetically from the stored pairs.

// File: rtl/dsr_pkg.sv
// Shared sizing for the dual-lane deserializer.
// Assumes an even word width split evenly over two lanes.
package dsr_pkg;
    localparam int HALF_W = 6;
    localparam int WORD_W = 2 * HALF_W;
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/dsr_frame_ctrl.sv
// Word-phase counter: issues a capture strobe once per HALF_W cycles.
// Assumes slip_req is synchronous; each high cycle freezes the phase once.
module dsr_frame_ctrl #(
    parameter int PERIOD = dsr_pkg::HALF_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slip_req,
    output logic cap_stb
);
    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] phase;

    // Strobe on the last phase unless a slip holds the counter this cycle.
    assign cap_stb = (phase == LAST) && !slip_req;

    // Advance the phase, wrapping at PERIOD, frozen while slipping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (!slip_req) begin
            phase <= (phase == LAST) ? '0 : phase + 1'b1;
        end
    end
endmodule

// File: rtl/dsr_cascade.sv
// One lane: a HALF_W-stage shift chain plus a parallel holding register.
// The holding register takes the chain including the current bit, so the
// newest bit lands in bit 0 and the oldest in bit HALF_W-1. Assumes HALF_W >= 2.
module dsr_cascade #(
    parameter int HALF_W = dsr_pkg::HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              din,
    input  logic              cap_stb,
    output logic [HALF_W-1:0] held
);
    logic [HALF_W-1:0] chain;
    logic [HALF_W-1:0] chain_nxt;

    // Next chain contents with the incoming bit appended.
    assign chain_nxt = {chain[HALF_W-2:0], din};

    // Shift one bit per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= chain_nxt;
    end

    // Copy the full lane into the holding register on the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       held <= '0;
        else if (cap_stb) held <= chain_nxt;
    end
endmodule

// File: rtl/dsr_word_mux.sv
// Interleaves two held lanes into the output word and registers it.
// Assumes swap_q and the held lanes are stable while load is high.
module dsr_word_mux #(
    parameter int HALF_W = dsr_pkg::HALF_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                swap_q,
    input  logic [HALF_W-1:0]   held_a,
    input  logic [HALF_W-1:0]   held_b,
    output logic [2*HALF_W-1:0] word_out,
    output logic                word_valid
);
    logic [2*HALF_W-1:0] word_nxt;

    // Per pair: the earlier bit goes to the higher position.
    for (genvar i = 0; i < HALF_W; i++) begin : g_pair
        assign word_nxt[2*i+1] = swap_q ? held_b[i] : held_a[i];
        assign word_nxt[2*i]   = swap_q ? held_a[i] : held_b[i];
    end

    // Final word register and its one-cycle valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_out   <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= load;
            if (load) word_out <= word_nxt;
        end
    end
endmodule

// File: rtl/dsr_deser12.sv
// Top level: two lane cascades, a word-phase counter and the interleaver.
// Assumes both lanes are already retimed to clk, one bit pair per cycle.
module dsr_deser12 #(
    parameter int HALF_W = dsr_pkg::HALF_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_rise,
    input  logic                bit_fall,
    input  logic                slip_req,
    input  logic                lane_swap,
    output logic [2*HALF_W-1:0] word_out,
    output logic                word_valid
);
    logic              cap_stb;
    logic              load_q;
    logic              swap_q;
    logic [1:0]        lane_in;
    logic [HALF_W-1:0] held [2];

    assign lane_in = {bit_fall, bit_rise};

    dsr_frame_ctrl #(.PERIOD(HALF_W)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .slip_req (slip_req),
        .cap_stb  (cap_stb)
    );

    for (genvar l = 0; l < 2; l++) begin : g_lane
        dsr_cascade #(.HALF_W(HALF_W)) u_casc (
            .clk     (clk),
            .rst_n   (rst_n),
            .din     (lane_in[l]),
            .cap_stb (cap_stb),
            .held    (held[l])
        );
    end

    // Delay the strobe to the output stage and latch the lane order with it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q <= 1'b0;
            swap_q <= 1'b0;
        end else begin
            load_q <= cap_stb;
            if (cap_stb) swap_q <= lane_swap;
        end
    end

    dsr_word_mux #(.HALF_W(HALF_W)) u_mux (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load_q),
        .swap_q     (swap_q),
        .held_a     (held[0]),
        .held_b     (held[1]),
        .word_out   (word_out),
        .word_valid (word_valid)
    );
endmodule

// File: rtl/dsr_deser12_sva.sv
// Protocol checks on the deserializer ports; bound to every dsr_deser12.
// Assumes slip requests only ever widen the spacing between words.
module dsr_deser12_sva #(
    parameter int HALF_W = dsr_pkg::HALF_W
) (
    input logic                clk,
    input logic                rst_n,
    input logic [2*HALF_W-1:0] word_out,
    input logic                word_valid
);
    logic [7:0] gap;
    logic       seen;

    // Cycles since the last valid, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if (word_valid) begin
            gap  <= '0;
            seen <= 1'b1;
        end else if (gap != 8'hFF) begin
            gap <= gap + 1'b1;
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!word_valid && word_out == '0));

    p_valid_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    p_word_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |-> $stable(word_out));

    p_min_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && seen) |-> (gap >= 8'(HALF_W - 1)));
endmodule

bind dsr_deser12 dsr_deser12_sva #(.HALF_W(HALF_W)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_out   (word_out),
    .word_valid (word_valid)
);

// File: tb/dsr_deser12_test.sv
module dsr_deser12_test;
    localparam int NE = 60;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_rise = 1'b0;
    logic        bit_fall = 1'b0;
    logic        slip_req = 1'b0;
    logic        lane_swap = 1'b0;
    logic [11:0] word_out;
    logic        word_valid;

    int checks = 0;
    int failures = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic pr [NE+1];
    logic pf [NE+1];

    always #2.5 clk = ~clk;

    dsr_deser12 uut (
        .clk(clk), .rst_n(rst_n), .bit_rise(bit_rise), .bit_fall(bit_fall),
        .slip_req(slip_req), .lane_swap(lane_swap),
        .word_out(word_out), .word_valid(word_valid)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] build(input int first, input bit sw);
        logic [11:0] w = '0;
        for (int j = 0; j < 6; j++) begin
            w[11-2*j] = sw ? pf[first+j] : pr[first+j];
            w[10-2*j] = sw ? pr[first+j] : pf[first+j];
        end
        return w;
    endfunction

    task automatic run(input int d, input bit sw);
        logic [11:0] last;
        bit exp_v;
        string tag;
        for (int e = 1; e <= NE; e++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            pr[e] = lfsr[0];
            pf[e] = lfsr[7];
        end
        rst_n = 1'b0; slip_req = 1'b0; lane_swap = ~sw;
        bit_rise = 1'b1; bit_fall = 1'b1;
        repeat (3) @(negedge clk);
        chk(word_valid == 1'b0 && word_out == '0, "R1 in reset", {word_valid, word_out}, 0);
        last = '0;
        rst_n = 1'b1;
        lane_swap = sw;
        for (int e = 1; e <= NE; e++) begin
            bit_rise = pr[e];
            bit_fall = pf[e];
            slip_req = (e <= d);
            @(negedge clk);
            exp_v = (e >= d + 7) && ((e - d - 7) % 6 == 0);
            if (e < d + 7)
                chk(!word_valid && word_out == '0, "R1 before first word", {word_valid, word_out}, 0);
            tag = (d == 0) ? "R2 valid timing" : "R5 slipped valid timing";
            chk(word_valid == exp_v, tag, word_valid, exp_v);
            if (exp_v) begin
                tag = sw ? "R4 swapped word" : "R3 word order";
                if (d != 0) tag = {tag, " R5 offset"};
                chk(word_out == build(e - 6, sw), tag, word_out, build(e - 6, sw));
                last = build(e - 6, sw);
            end else begin
                chk(word_out == last, "R6 word held", word_out, last);
            end
        end
        slip_req = 1'b0;
    endtask

    initial begin
        #1000000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int sw = 0; sw < 2; sw++)
            for (int d = 0; d < 6; d++)
                run(d, sw[0]);
        // R7: spacing between pulses checked across the sweep by exact timing above.
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule